// File: doc/BRIEF.md
# Byte-Parallel Configuration Receiver

This block is the target side of a byte-wide configuration load port. An external host drives a configuration clock, an active-low select, an active-low write strobe and an 8-bit data bus. On each rising clock edge where the host selects the port, drives write low and sees the busy line low, the receiver latches the byte into a single-entry holding register. It then offers that byte to an internal consumer over a valid/ready handshake.

The busy line is the back-pressure path. While the consumer has not yet taken the held byte and the port is selected, busy stays high. During that time the host must keep the same byte on the bus. It is accepted at the first edge where busy is low.

While select stays low, the write strobe must not change level between two consecutive edges. If it does, the receiver discards any held byte and enters a sticky abort state that blocks further captures. The abort state is reported on a status output and is left only when select is released. A running count of accepted bytes is also exposed.

Top module: `cfg_byte_rx`

## Requirements
- R1: Under reset (rst_ni low) busy_o, out_valid_o and abort_o are 0 and byte_count_o is 0.
- R2: At a rising edge where sel_ni=0, wr_ni=0, busy_o=0, abort_o=0 and write kept its level from the previous selected edge, data_i is captured. After that edge out_valid_o=1 and out_data_o equals the captured byte.
- R3: busy_o is 1 whenever sel_ni=0 and the holding register is full. A byte presented at an edge where busy_o=1 is not captured: out_data_o and byte_count_o keep their values.
- R4: At an edge with out_valid_o=1 and out_ready_i=1, the holding register empties, so out_valid_o=0 after that edge. No new byte is captured at that edge.
- R5: At an edge with sel_ni=0 and wr_ni=1, no byte is captured.
- R6: While sel_ni=1, busy_o is 0 and no byte is captured. A byte already held stays offered on the consumer side.
- R7: If sel_ni=0 at two consecutive rising edges and wr_ni differs between them, abort_o=1 after the second edge. Any held byte is dropped (out_valid_o=0), and nothing is captured at that edge.
- R8: While abort_o=1 no byte is captured. abort_o returns to 0 after the first rising edge where sel_ni=1.
- R9: byte_count_o increments by one for each captured byte and wraps from 2^CNT_W-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Configuration clock; all state changes on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_ni | input | 1 | Port select from the host, active low |
| wr_ni | input | 1 | Write strobe from the host, active low (low = host writes) |
| data_i | input | DATA_W | Configuration byte from the host |
| busy_o | output | 1 | Back-pressure to the host; high means the byte is not taken |
| out_valid_o | output | 1 | Holding register has a byte for the consumer |
| out_data_o | output | DATA_W | Byte offered to the consumer |
| out_ready_i | input | 1 | Consumer takes the offered byte at this edge |
| abort_o | output | 1 | Sticky abort status, cleared by deselect |
| byte_count_o | output | CNT_W | Number of accepted bytes, modulo 2^CNT_W |

## Verification
The bound checker tests the cycle-local rules at every edge:
- capture under the full set of enabling conditions;
- no capture with write high, while deselected or while aborted;
- busy forced low when deselected, and the held byte kept stable under a stall;
- the pop on a handshake;
- abort entry on a write-level change under continuous select, and abort exit on deselect;
- the count moving by zero or one.

Some behaviours span several cycles and only the bench scenarios show them. These are:
- a held byte surviving deselection;
- a stalled byte being the one finally accepted after the drain;
- the count wrapping after sixteen bytes with a narrowed counter;
- a mid-stream reset clearing a full holding register.

// File: rtl/cfg_rx_pkg.sv
package cfg_rx_pkg;
  typedef enum logic {
    RX_RUN   = 1'b0,
    RX_ABORT = 1'b1
  } rx_state_e;
endpackage

// File: rtl/cfg_rx_abort_det.sv
module cfg_rx_abort_det
  import cfg_rx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_ni,
  input  logic wr_ni,
  output logic abort_evt_o,
  output logic abort_o
);
  logic      prev_sel_q;
  logic      prev_wr_q;
  rx_state_e state_q;

  // write level change across two selected edges
  assign abort_evt_o = ~sel_ni & prev_sel_q & (wr_ni ^ prev_wr_q);
  assign abort_o     = (state_q == RX_ABORT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_sel_q <= 1'b0;
      prev_wr_q  <= 1'b1;
      state_q    <= RX_RUN;
    end else begin
      prev_sel_q <= ~sel_ni;
      prev_wr_q  <= wr_ni;
      if (sel_ni)           state_q <= RX_RUN;
      else if (abort_evt_o) state_q <= RX_ABORT;
    end
  end
endmodule

// File: rtl/cfg_rx_hold.sv
module cfg_rx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              drop_i,
  input  logic              out_ready_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o
);
  logic              vld_q;
  logic [DATA_W-1:0] data_q;

  assign out_valid_o = vld_q;
  assign out_data_o  = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      data_q <= '0;
    end else if (drop_i) begin
      vld_q <= 1'b0;
    end else if (load_i) begin
      vld_q  <= 1'b1;
      data_q <= load_data_i;
    end else if (vld_q && out_ready_i) begin
      vld_q <= 1'b0;
    end
  end
endmodule

// File: rtl/cfg_rx_counter.sv
module cfg_rx_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] cnt_q;

  assign count_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/cfg_byte_rx.sv
module cfg_byte_rx #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_ni,
  input  logic              wr_ni,
  input  logic [DATA_W-1:0] data_i,
  output logic              busy_o,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o,
  input  logic              out_ready_i,
  output logic              abort_o,
  output logic [CNT_W-1:0]  byte_count_o
);
  logic abort_evt;
  logic abort_st;
  logic hold_vld;
  logic accept;

  cfg_rx_abort_det u_abort (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sel_ni      (sel_ni),
    .wr_ni       (wr_ni),
    .abort_evt_o (abort_evt),
    .abort_o     (abort_st)
  );

  // busy only while selected and the holding slot is occupied
  assign busy_o = ~sel_ni & hold_vld;
  assign accept = ~sel_ni & ~wr_ni & ~busy_o & ~abort_st & ~abort_evt;

  cfg_rx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (accept),
    .load_data_i (data_i),
    .drop_i      (abort_evt),
    .out_ready_i (out_ready_i),
    .out_valid_o (hold_vld),
    .out_data_o  (out_data_o)
  );

  cfg_rx_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .inc_i   (accept),
    .count_o (byte_count_o)
  );

  assign out_valid_o = hold_vld;
  assign abort_o     = abort_st;
endmodule

// File: rtl/cfg_rx_chk.sv
module cfg_rx_chk #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sel_ni,
  input logic              wr_ni,
  input logic [DATA_W-1:0] data_i,
  input logic              busy_o,
  input logic              out_valid_o,
  input logic [DATA_W-1:0] out_data_o,
  input logic              out_ready_i,
  input logic              abort_o,
  input logic [CNT_W-1:0]  byte_count_o
);
  logic sel_seen_q;
  logic wr_seen_q;
  logic flip_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_seen_q <= 1'b0;
      wr_seen_q  <= 1'b1;
    end else begin
      sel_seen_q <= !sel_ni;
      wr_seen_q  <= wr_ni;
    end
  end

  assign flip_c = !sel_ni && sel_seen_q && (wr_ni != wr_seen_q);

  AST_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_ni && !wr_ni && !busy_o && !abort_o && !flip_c) |=>
      (out_valid_o && out_data_o == $past(data_i)
       && byte_count_o == CNT_W'($past(byte_count_o) + 1'b1)));  // R2
  AST_STALL_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !out_ready_i && !flip_c) |=> (out_valid_o && $stable(out_data_o)));  // R3
  AST_STALL_NO_CNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(byte_count_o));  // R3
  AST_HS_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i) |=> !out_valid_o);  // R4
  AST_WR_HIGH_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_ni && wr_ni) |=> $stable(byte_count_o));  // R5
  AST_DESEL_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_ni |-> !busy_o);  // R6
  AST_DESEL_NO_CNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_ni |=> $stable(byte_count_o));  // R6
  AST_ABORT_ENTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flip_c |=> (abort_o && !out_valid_o && $stable(byte_count_o)));  // R7
  AST_ABORT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_o && !sel_ni) |=> (abort_o && $stable(byte_count_o)));  // R8
  AST_ABORT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_ni |=> !abort_o);  // R8
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (byte_count_o == $past(byte_count_o)
              || byte_count_o == CNT_W'($past(byte_count_o) + 1'b1)));  // R9
endmodule

bind cfg_byte_rx cfg_rx_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sel_ni       (sel_ni),
  .wr_ni        (wr_ni),
  .data_i       (data_i),
  .busy_o       (busy_o),
  .out_valid_o  (out_valid_o),
  .out_data_o   (out_data_o),
  .out_ready_i  (out_ready_i),
  .abort_o      (abort_o),
  .byte_count_o (byte_count_o)
);

// File: tb/sim_cfg_byte_rx.sv
module sim_cfg_byte_rx;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 8;
  localparam int CNT_W      = 4;

  typedef struct packed {
    logic       sel_n;
    logic       wr_n;
    logic [7:0] d;
    logic       rdy;
    logic       ev;
    logic [7:0] ed;
    logic       eb;
    logic       ea;
    logic [3:0] ec;
    logic [3:0] rq;
  } vec_t;

  // inputs for one edge, expected outputs after it
  localparam int NV = 18;
  localparam vec_t TBL [NV] = '{
    '{1'b1,1'b1,8'h00,1'b0, 1'b0,8'h00,1'b0,1'b0,4'd0,4'd6}, // R6 idle
    '{1'b0,1'b0,8'hA5,1'b0, 1'b1,8'hA5,1'b1,1'b0,4'd1,4'd2}, // R2 capture
    '{1'b0,1'b0,8'h3C,1'b0, 1'b1,8'hA5,1'b1,1'b0,4'd1,4'd3}, // R3 stall
    '{1'b0,1'b0,8'h3C,1'b1, 1'b0,8'h00,1'b0,1'b0,4'd1,4'd4}, // R4 pop, no take
    '{1'b0,1'b0,8'h3C,1'b0, 1'b1,8'h3C,1'b1,1'b0,4'd2,4'd3}, // R3 held byte taken
    '{1'b0,1'b0,8'h3C,1'b1, 1'b0,8'h00,1'b0,1'b0,4'd2,4'd4},
    '{1'b1,1'b1,8'h77,1'b0, 1'b0,8'h00,1'b0,1'b0,4'd2,4'd6},
    '{1'b0,1'b1,8'h55,1'b0, 1'b0,8'h00,1'b0,1'b0,4'd2,4'd5}, // R5
    '{1'b0,1'b1,8'h66,1'b0, 1'b0,8'h00,1'b0,1'b0,4'd2,4'd5},
    '{1'b1,1'b1,8'h00,1'b0, 1'b0,8'h00,1'b0,1'b0,4'd2,4'd6},
    '{1'b0,1'b0,8'h11,1'b0, 1'b1,8'h11,1'b1,1'b0,4'd3,4'd2},
    '{1'b0,1'b1,8'h11,1'b0, 1'b0,8'h00,1'b0,1'b1,4'd3,4'd7}, // R7 drop
    '{1'b0,1'b0,8'h22,1'b0, 1'b0,8'h00,1'b0,1'b1,4'd3,4'd8}, // R8 blocked
    '{1'b0,1'b0,8'h22,1'b0, 1'b0,8'h00,1'b0,1'b1,4'd3,4'd8},
    '{1'b1,1'b1,8'h00,1'b0, 1'b0,8'h00,1'b0,1'b0,4'd3,4'd8}, // R8 clear
    '{1'b0,1'b0,8'h99,1'b1, 1'b1,8'h99,1'b1,1'b0,4'd4,4'd2},
    '{1'b0,1'b0,8'h99,1'b1, 1'b0,8'h00,1'b0,1'b0,4'd4,4'd4},
    '{1'b1,1'b1,8'h00,1'b0, 1'b0,8'h00,1'b0,1'b0,4'd4,4'd6}
  };

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              sel_ni = 1'b1;
  logic              wr_ni = 1'b1;
  logic [DATA_W-1:0] data_i = '0;
  logic              out_ready_i = 1'b0;
  logic              busy_o, out_valid_o, abort_o;
  logic [DATA_W-1:0] out_data_o;
  logic [CNT_W-1:0]  byte_count_o;
  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_byte_rx #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sel_ni(sel_ni), .wr_ni(wr_ni), .data_i(data_i),
    .busy_o(busy_o), .out_valid_o(out_valid_o), .out_data_o(out_data_o),
    .out_ready_i(out_ready_i), .abort_o(abort_o), .byte_count_o(byte_count_o)
  );

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(logic s, logic w, logic [7:0] d, logic r);
    @(negedge clk);
    sel_ni = s; wr_ni = w; data_i = d; out_ready_i = r;
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  initial begin
    #(CLK_PERIOD*50000);
    total++; bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "busy", busy_o, 0);
    chk("R1", "valid", out_valid_o, 0);
    chk("R1", "abort", abort_o, 0);
    chk("R1", "count", byte_count_o, 0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d#%0d", TBL[i].rq, i);
      cyc(TBL[i].sel_n, TBL[i].wr_n, TBL[i].d, TBL[i].rdy);
      chk(tag, "valid", out_valid_o, TBL[i].ev);
      chk(tag, "busy", busy_o, TBL[i].eb);
      chk(tag, "abort", abort_o, TBL[i].ea);
      chk(tag, "count", byte_count_o, TBL[i].ec);
      if (TBL[i].ev) chk(tag, "data", out_data_o, TBL[i].ed);
    end

    // R6 held byte stays offered across deselect, busy low
    cyc(1'b0, 1'b0, 8'hC3, 1'b0);
    chk("R2", "count", byte_count_o, 5);
    cyc(1'b1, 1'b1, 8'h00, 1'b0);
    chk("R6", "valid", out_valid_o, 1);
    chk("R6", "busy", busy_o, 0);
    chk("R6", "data", out_data_o, 8'hC3);
    cyc(1'b1, 1'b1, 8'h00, 1'b1);
    chk("R4", "valid", out_valid_o, 0);

    // R7 write going high to low under select also aborts
    cyc(1'b0, 1'b1, 8'h00, 1'b0);
    cyc(1'b0, 1'b0, 8'h44, 1'b0);
    chk("R7", "abort", abort_o, 1);
    chk("R7", "valid", out_valid_o, 0);
    chk("R7", "count", byte_count_o, 5);
    cyc(1'b1, 1'b1, 8'h00, 1'b0);
    chk("R8", "abort", abort_o, 0);

    // R9 wrap of the narrowed counter
    for (int k = 0; k < 11; k++) begin
      cyc(1'b0, 1'b0, 8'(k + 1), 1'b0);
      chk("R9", "count", byte_count_o, (6 + k) % 16);
      cyc(1'b0, 1'b0, 8'(k + 1), 1'b1);
    end
    chk("R9", "wrap", byte_count_o, 0);

    // R1 asynchronous reset with a full holding register
    cyc(1'b0, 1'b0, 8'h5A, 1'b0);
    chk("R2", "valid", out_valid_o, 1);
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk("R1", "valid", out_valid_o, 0);
    chk("R1", "busy", busy_o, 0);
    chk("R1", "count", byte_count_o, 0);
    sel_ni = 1'b1; wr_ni = 1'b1;
    @(negedge clk);
    rst_ni = 1'b1;
    cyc(1'b1, 1'b1, 8'h00, 1'b0);
    chk("R1", "abort", abort_o, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule